// File: doc/BRIEF.md
# Transmit Byte-Group Pacing Throttle

This block slows down a transmit path that accepts bytes instantly, so that its average throughput follows a programmed baud rate. Bytes are never delayed one by one. The block counts every byte write. After each group of bytes whose size comes from the baud rate, it withholds the transmit-ready notification for a fixed pause window. When the window ends, it raises transmit-ready again.

The baud rate is a fixed base rate of 115200 divided by a 16-bit divisor. Software supplies the divisor through an update strobe. A sequential divider then computes the group size as ten times the integer number of thousands of 8-bit characters per second. No divide is done in a single cycle. Pacing applies only while the transmit interrupt enable is set. A group size of zero turns pacing off.

Top module: `pace_throttle`

## Requirements
- R1: After reset the divisor is 1, so the group size is 140. `pause_busy` and `txrdy_set` are low.
- R2: A nonzero divisor `d` on `div_stb` sets the group size to 10 × floor(floor(floor(115200/d)/8)/1000). The new size takes effect within 40 cycles, and the byte count restarts at zero.
- R3: A divisor update with value 0 is ignored. The previous group size and the byte count stay in effect.
- R4: With `tx_irq_en` high, a write that does not complete a group makes `txrdy_set` high for one cycle, in the cycle after the write.
- R5: With `tx_irq_en` high and no pause active, a write that completes a group gives no immediate `txrdy_set`. Instead, `pause_busy` is high for exactly PAUSE_MS × CYC_PER_MS cycles, starting the cycle after the write.
- R6: When a pause expires, `txrdy_set` is high in the cycle right after the last busy cycle.
- R7: With `tx_irq_en` low, writes produce neither `txrdy_set` nor a pause, but they are still counted toward the group.
- R8: When the group size is 0 (divisor 15 or more), every write with `tx_irq_en` high gives an immediate `txrdy_set`, and no pause ever starts.
- R9: Writes made during a pause are counted. A write that completes a group during a pause neither starts nor extends a pause, and it gives no `txrdy_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One transmit byte written this cycle |
| tx_irq_en | input | 1 | Transmit interrupt enable; pacing acts only while high |
| div_stb | input | 1 | Divisor update strobe |
| div_val | input | DIV_W (16) | Divisor value sampled with `div_stb` |
| txrdy_set | output | 1 | One-cycle transmit-ready set / interrupt request |
| pause_busy | output | 1 | High while a pause window is running |

## Verification
The bench builds the block with CYC_PER_MS = 3, which gives a 30-cycle pause window. Several whole pauses, including writes that land inside them, then fit into a short run. Divisors of 1, 2, 3, 7 and 14 give group sizes of 140, 70, 40, 20 and 10. These let group boundaries fall both outside and inside a pause. A divisor of 15 reaches the zero-size case that turns pacing off. A divisor of 0 reaches the rejected update.

// File: rtl/pace_pkg.sv
package pace_pkg;
  // group size from the character-rate quotient (thousands of chars per second)
  function automatic int unsigned pace_group(input int unsigned quot, input int unsigned pause_ms);
    return quot * pause_ms;
  endfunction
  // one combined divide equals the nested integer divides
  function automatic int unsigned pace_quot(input int unsigned base, input int unsigned d,
                                            input int unsigned char_bits);
    return base / (d * char_bits * 1000);
  endfunction
endpackage

// File: rtl/pace_grp_calc.sv
module pace_grp_calc import pace_pkg::*; #(
  parameter int BASE_BAUD = 115200,
  parameter int CHAR_BITS = 8,
  parameter int PAUSE_MS  = 10,
  parameter int DIV_W     = 16,
  parameter int GRP_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_stb,
  input  logic [DIV_W-1:0] div_val,
  output logic [GRP_W-1:0] grp,
  output logic             grp_load
);
  localparam int DVD_W = $clog2(BASE_BAUD + 1);
  localparam int DEN_W = 32;
  localparam int IDX_W = (DVD_W > 1) ? $clog2(DVD_W) : 1;
  localparam logic [DVD_W-1:0] DVD  = DVD_W'(BASE_BAUD);
  localparam logic [DEN_W-1:0] UNIT = DEN_W'(CHAR_BITS * 1000);
  localparam logic [GRP_W-1:0] RST_GRP = GRP_W'(pace_group(pace_quot(BASE_BAUD, 1, CHAR_BITS), PAUSE_MS));

  logic             running;
  logic [IDX_W-1:0] idx;
  logic [DEN_W-1:0] den, rem;
  logic [DVD_W-1:0] quo;
  logic [DEN_W:0]   trial;
  logic             fits;
  logic [DEN_W-1:0] rem_nxt;
  logic [DVD_W-1:0] quo_nxt;
  logic             accept;

  assign accept  = div_stb && (div_val != '0);
  assign trial   = {rem, DVD[idx]};
  assign fits    = trial >= {1'b0, den};
  assign rem_nxt = fits ? DEN_W'(trial - {1'b0, den}) : trial[DEN_W-1:0];
  assign quo_nxt = {quo[DVD_W-2:0], fits};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      idx      <= '0;
      den      <= '0;
      rem      <= '0;
      quo      <= '0;
      grp      <= RST_GRP;
      grp_load <= 1'b0;
    end else begin
      grp_load <= 1'b0;
      if (accept) begin
        running <= 1'b1;
        idx     <= IDX_W'(DVD_W - 1);
        den     <= DEN_W'(div_val) * UNIT;
        rem     <= '0;
        quo     <= '0;
      end else if (running) begin
        rem <= rem_nxt;
        quo <= quo_nxt;
        if (idx == '0) begin
          running  <= 1'b0;
          grp      <= GRP_W'(pace_group(32'(quo_nxt), PAUSE_MS));
          grp_load <= 1'b1;
        end else begin
          idx <= idx - 1'b1;
        end
      end
    end
  end

  // a zero divisor must not launch a computation
  assert_zero_div_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_stb && div_val == '0 && !running) |=> !running);
  // group size only moves together with a load pulse
  assert_grp_changes_on_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_load |-> $stable(grp) || $past(!rst_n));
endmodule

// File: rtl/pace_byte_cnt.sv
module pace_byte_cnt #(
  parameter int GRP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             load,
  input  logic [GRP_W-1:0] grp,
  output logic             wrap
);
  logic [GRP_W-1:0] cnt;
  logic [GRP_W-1:0] nxt;

  assign nxt  = cnt + 1'b1;
  assign wrap = wr && (grp != '0) && (nxt == grp);

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt <= '0;
    else if (load)                  cnt <= '0;
    else if (wr)                    cnt <= (grp == '0 || nxt == grp) ? '0 : nxt;
  end

  assert_cnt_below_group_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (grp != '0) |-> (cnt < grp));
endmodule

// File: rtl/pace_pause_tmr.sv
module pace_pause_tmr #(
  parameter int PAUSE_CYC = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic expire
);
  localparam int TW = (PAUSE_CYC > 1) ? $clog2(PAUSE_CYC) : 1;
  logic [TW-1:0] tmr;

  assign expire = busy && (tmr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tmr  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      tmr  <= TW'(PAUSE_CYC - 1);
    end else if (expire) begin
      busy <= 1'b0;
    end else if (busy) begin
      tmr <= tmr - 1'b1;
    end
  end

  // a running pause is never cut short or restarted
  assert_pause_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tmr != '0) |=> busy && (tmr == $past(tmr) - 1'b1));
endmodule

// File: rtl/pace_throttle.sv
module pace_throttle #(
  parameter int BASE_BAUD  = 115200,
  parameter int CHAR_BITS  = 8,
  parameter int PAUSE_MS   = 10,
  parameter int CYC_PER_MS = 100000,
  parameter int DIV_W      = 16,
  parameter int GRP_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic             tx_irq_en,
  input  logic             div_stb,
  input  logic [DIV_W-1:0] div_val,
  output logic             txrdy_set,
  output logic             pause_busy
);
  localparam int PAUSE_CYC = PAUSE_MS * CYC_PER_MS;

  logic [GRP_W-1:0] grp;
  logic             grp_load;
  logic             grp_wrap;
  logic             pause_start;
  logic             pause_expire;
  logic             imm_ready;

  pace_grp_calc #(
    .BASE_BAUD(BASE_BAUD), .CHAR_BITS(CHAR_BITS), .PAUSE_MS(PAUSE_MS),
    .DIV_W(DIV_W), .GRP_W(GRP_W)
  ) u_calc (
    .clk(clk), .rst_n(rst_n), .div_stb(div_stb), .div_val(div_val),
    .grp(grp), .grp_load(grp_load)
  );

  pace_byte_cnt #(.GRP_W(GRP_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr(wr_stb), .load(grp_load), .grp(grp), .wrap(grp_wrap)
  );

  assign pause_start = grp_wrap && tx_irq_en && !pause_busy;
  assign imm_ready   = wr_stb && tx_irq_en && !grp_wrap;

  pace_pause_tmr #(.PAUSE_CYC(PAUSE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(pause_start), .busy(pause_busy), .expire(pause_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) txrdy_set <= 1'b0;
    else        txrdy_set <= imm_ready || pause_expire;
  end

  assert_no_pause_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grp == '0) |-> !pause_start);
  assert_pause_no_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_busy) |-> !txrdy_set);
  assert_expiry_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pause_busy) |-> txrdy_set);
  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !tx_irq_en && !pause_busy) |=> !pause_busy);
endmodule

// File: tb/test_pace_throttle.sv
`timescale 1ns/1ps
module test_pace_throttle;
  localparam int CPM = 3;
  localparam int PMS = 10;
  localparam int PCYC = CPM * PMS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0, tx_irq_en = 1'b0, div_stb = 1'b0;
  logic [15:0] div_val = '0;
  logic txrdy_set, pause_busy;

  int total = 0, bad = 0, cyc = 0;
  string tag = "R1";
  // reference model state
  int m_grp = 140, m_bytes = 0, m_left = 0;
  bit m_rdy = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pace_throttle #(.PAUSE_MS(PMS), .CYC_PER_MS(CPM)) i_pace_throttle (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .tx_irq_en(tx_irq_en),
    .div_stb(div_stb), .div_val(div_val), .txrdy_set(txrdy_set), .pause_busy(pause_busy));

  always @(posedge clk) begin
    bit active, boundary;
    if (!rst_n) begin
      m_grp = 140; m_bytes = 0; m_left = 0; m_rdy = 0;
    end else begin
      m_rdy = 0;
      active = (m_left > 0);
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) m_rdy = 1;
      end
      if (wr_stb) begin
        m_bytes++;
        boundary = (m_grp != 0) && (m_bytes % m_grp == 0);
        if (tx_irq_en) begin
          if (!boundary) m_rdy = 1;
          else if (!active) m_left = PCYC;
        end
      end
      if (div_stb && div_val != 0) begin
        m_grp = (((115200 / div_val) / 8) / 1000) * 10;
        m_bytes = 0;
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(tag, txrdy_set, m_rdy, "txrdy_set");
      check(tag, pause_busy, m_left > 0, "pause_busy");
    end
  end

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      report();
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wr_stb <= 1'b1;
      @(negedge clk); wr_stb <= 1'b0;
      idle(gap);
    end
  endtask

  task automatic set_div(input int d);
    @(negedge clk); div_stb <= 1'b1; div_val <= 16'(d);
    @(negedge clk); div_stb <= 1'b0; div_val <= '0;
    idle(40);
  endtask

  initial begin
    idle(3);
    check("R1", txrdy_set, 1'b0, "reset txrdy_set");
    check("R1", pause_busy, 1'b0, "reset pause_busy");
    @(negedge clk); rst_n <= 1'b1;
    tx_irq_en <= 1'b1;
    tag = "R4"; write(139, 0);
    check("R1", pause_busy, 1'b0, "no pause before 140th byte");
    tag = "R5"; write(1, 0);
    check("R5", pause_busy, 1'b1, "pause after full group of 140");
    tag = "R6"; idle(PCYC + 3);
    check("R6", pause_busy, 1'b0, "pause over");
    tag = "R2"; set_div(14); write(10, 0);
    check("R2", pause_busy, 1'b1, "group of 10 pauses");
    tag = "R9"; write(10, 0);
    idle(PCYC);
    check("R9", pause_busy, 1'b0, "no extension by boundary in pause");
    write(10, 1);
    check("R9", pause_busy, 1'b1, "next group pauses after pause");
    idle(PCYC + 2);
    tag = "R3"; write(3, 0); set_div(0); write(7, 0);
    check("R3", pause_busy, 1'b1, "zero divisor kept group 10 and count");
    idle(PCYC + 2);
    tag = "R7"; tx_irq_en <= 1'b0; write(25, 0);
    check("R7", pause_busy, 1'b0, "no pause while disabled");
    tx_irq_en <= 1'b1; write(5, 0);
    check("R7", pause_busy, 1'b1, "disabled writes still counted");
    idle(PCYC + 2);
    tag = "R8"; set_div(15); write(20, 0);
    check("R8", pause_busy, 1'b0, "zero group never pauses");
    tag = "R2";
    set_div(2); write(70, 0); check("R2", pause_busy, 1'b1, "d=2 group 70"); idle(PCYC + 2);
    set_div(3); write(40, 1); check("R2", pause_busy, 1'b1, "d=3 group 40"); idle(PCYC + 2);
    set_div(7); write(19, 0); check("R2", pause_busy, 1'b0, "d=7 before 20th");
    write(1, 0); check("R2", pause_busy, 1'b1, "d=7 group 20"); idle(PCYC + 2);
    set_div(1); write(140, 0); check("R2", pause_busy, 1'b1, "d=1 group 140");
    idle(PCYC + 4);
    report();
  end
endmodule